// File: doc/BRIEF.md
# Baud-Rate Clock Generator Bank

A bank of eight independent baud-rate clock generators driven by a single reference clock. Each generator has one 32-bit control word written over a simple register bus. The word holds an enable flag, an optional divide-by-16 prescaler select and a divisor. While a generator is enabled it emits a one-cycle tick every (divisor + 1) prescaled reference cycles. It also toggles a square-wave clock output on each tick, so that output can be driven off-chip as a clock. Asynchronous serial users set the prescaler to get a 16x oversampled rate. High-speed synchronous users usually leave the prescaler off.

The generators sit in two banks of four. A register address is formed from a bank bit and a two-bit slot, and the zero-based generator index is `bank*4 + slot`. Each generator runs a two-state machine. In ST_OFF the counters and outputs are held cleared. In ST_RUN the prescaler and the divisor counter count down. Reset forces ST_OFF. A write whose enable flag is set moves the generator to ST_RUN, and a write whose enable flag is clear moves it to ST_OFF. In both cases the write restarts the counters from the new value.

Top module: `baud_gen_bank`

## Requirements
- R1: After reset every control word reads 0, and every tick and clock output is 0.
- R2: `bus_addr[2]` selects the bank and `bus_addr[1:0]` the slot. A write with `bus_wr` high changes only generator `bus_addr[2]*4 + bus_addr[1:0]`.
- R3: `bus_rdata` combinationally returns all 32 bits last written to the addressed control word.
- R4: Control word layout: bit 16 is enable, bit 0 selects the divide-by-16 prescaler, and bits 12:1 hold the divisor D. All other bits are stored but have no effect.
- R5: With the prescaler off and the generator enabled, the first tick is high in the cycle after clock edge D+1, counted from the edge that captured the write. After that, ticks repeat every D+1 cycles. A write clears the tick and clock outputs.
- R6: With the prescaler on, the first tick comes 16*(D+1) edges after the write edge, and ticks repeat every 16*(D+1) cycles.
- R7: With the enable bit clear, the tick and clock outputs of that generator stay 0. Writing a disabled word to a running generator stops it.
- R8: A write to one generator does not disturb the tick phase of any other generator.
- R9: The clock output toggles on every tick, giving a square wave of period 2*(D+1) prescaled cycles.
- R10: With D = 0 and the prescaler off, the tick is high on every cycle while the generator is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | {bank, slot} register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of addressed control word |
| brg_tick | output | 8 | One-cycle tick per generator |
| brg_clk | output | 8 | Square-wave clock per generator |

## Verification
A divisor counter or prescaler in a wrong state shows up as a tick that comes one or more cycles early or late. The error is visible at the first tick after a write, which is at most 16*(D+1) cycles later. A write decoded to the wrong generator shows up at once in read-back, and as a phase jump in a bystander's tick train within one period. A stuck state machine shows up either as ticks from a disabled generator or as no tick at all where one is due.

// File: rtl/brg_pkg.sv
package brg_pkg;
    typedef enum logic {ST_OFF = 1'b0, ST_RUN = 1'b1} brg_state_e;
    localparam int CTL_EN_BIT  = 16;
    localparam int CTL_PRE_BIT = 0;
    localparam int PRE_RATIO   = 16;
endpackage

// File: rtl/brg_decode.sv
module brg_decode #(
    parameter int NUM_GEN = 8,
    parameter int DATA_W  = 32,
    localparam int ADDR_W = $clog2(NUM_GEN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [NUM_GEN*DATA_W-1:0] cfg_flat,
    output logic [NUM_GEN-1:0]        wr_stb,
    output logic [DATA_W-1:0]         rdata
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_stb
        assign wr_stb[g] = bus_wr && (bus_addr == ADDR_W'(g));
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (bus_addr == ADDR_W'(g)) rdata = cfg_flat[g*DATA_W +: DATA_W];
        end
    end

    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb) && (bus_wr == (wr_stb != '0)));
endmodule

// File: rtl/brg_channel.sv
module brg_channel
    import brg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 12,
    localparam int PRE_W = $clog2(PRE_RATIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_o,
    output logic              tick_o,
    output logic              clk_o
);
    brg_state_e        state_q, state_d;
    logic [DATA_W-1:0] cfg_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [PRE_W-1:0]  pre_q;
    logic              tick_q, clk_q;
    logic [DIV_W-1:0]  div_f;
    logic              pre_on, step;

    assign div_f  = cfg_q[DIV_W:1];
    assign pre_on = cfg_q[CTL_PRE_BIT];
    assign step   = !pre_on || (pre_q == PRE_W'(PRE_RATIO - 1));

    always_comb begin
        state_d = state_q;
        if (wr_stb) state_d = wdata[CTL_EN_BIT] ? ST_RUN : ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cnt_q  <= '0;
            pre_q  <= '0;
            tick_q <= 1'b0;
            clk_q  <= 1'b0;
        end else if (wr_stb) begin
            cfg_q  <= wdata;
            cnt_q  <= wdata[DIV_W:1];
            pre_q  <= '0;
            tick_q <= 1'b0;
            clk_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_q  <= div_f;
                    pre_q  <= '0;
                    tick_q <= 1'b0;
                    clk_q  <= 1'b0;
                end
                ST_RUN: begin
                    tick_q <= 1'b0;
                    if (pre_on) pre_q <= pre_q + 1'b1;
                    if (step) begin
                        if (cnt_q == '0) begin
                            cnt_q  <= div_f;
                            tick_q <= 1'b1;
                            clk_q  <= ~clk_q;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign cfg_o  = cfg_q;
    assign tick_o = tick_q;
    assign clk_o  = clk_q;

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!tick_q && !clk_q));
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div_f);
    // R6
    pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_on |-> (pre_q == '0));
    // R9
    clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> (clk_q != $past(clk_q)));
endmodule

// File: rtl/baud_gen_bank.sv
module baud_gen_bank #(
    parameter int NUM_BANKS = 2,
    parameter int PER_BANK  = 4,
    parameter int DATA_W    = 32,
    parameter int DIV_W     = 12,
    localparam int NUM_GEN  = NUM_BANKS * PER_BANK,
    localparam int ADDR_W   = $clog2(NUM_GEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_GEN-1:0] brg_tick,
    output logic [NUM_GEN-1:0] brg_clk
);
    logic [NUM_GEN-1:0]        wr_stb;
    logic [NUM_GEN*DATA_W-1:0] cfg_flat;

    brg_decode #(.NUM_GEN(NUM_GEN), .DATA_W(DATA_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .cfg_flat(cfg_flat), .wr_stb(wr_stb), .rdata(bus_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar s = 0; s < PER_BANK; s++) begin : g_slot
            localparam int IDX = b * PER_BANK + s;
            brg_channel #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chan (
                .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb[IDX]),
                .wdata(bus_wdata), .cfg_o(cfg_flat[IDX*DATA_W +: DATA_W]),
                .tick_o(brg_tick[IDX]), .clk_o(brg_clk[IDX])
            );
        end
    end
endmodule

// File: tb/baud_gen_bank_bench.sv
`timescale 1ns/1ps
module baud_gen_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  brg_tick, brg_clk;
    int total = 0, fails = 0;

    always #10 clk = ~clk;

    baud_gen_bank u_baud_gen_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .brg_tick(brg_tick), .brg_clk(brg_clk)
    );

    function automatic logic [31:0] mk(input bit en, input bit p16, input int d);
        return (32'(en) << 16) | (32'(d) << 1) | 32'(p16);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_tick(input int g, input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!brg_tick[g] && n < limit);
    endtask

    initial begin
        int n, exp_p, k_a, k_b;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        chk(brg_tick == 0 && brg_clk == 0, "R1 outputs", {brg_tick, brg_clk}, 0);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); bus_addr = 3'(a); #1;
            chk(bus_rdata == 0, "R1 readback", bus_rdata, 0);
        end
        // R2 R3 R4 read-back of every word, all bits kept
        for (int a = 0; a < 8; a++) wr(a, 32'hA5C3_0F1E ^ (32'(a) * 32'h0101_1011));
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); bus_addr = 3'(a); #1;
            chk(bus_rdata == (32'hA5C3_0F1E ^ (32'(a) * 32'h0101_1011)), "R2 R3 R4 readback",
                bus_rdata, 32'hA5C3_0F1E ^ (32'(a) * 32'h0101_1011));
        end
        for (int a = 0; a < 8; a++) wr(a, 0);
        // R5 R6 R9 R10 period sweep on every generator
        for (int g = 0; g < 8; g++) begin
            for (int p = 0; p < 2; p++) begin
                for (int di = 0; di < 4; di++) begin
                    int d;
                    d = (di == 3) ? 5 : di;
                    exp_p = (p != 0) ? 16 * (d + 1) : d + 1;
                    wr(g, mk(1'b1, p[0], d));
                    chk(brg_clk[g] == 1'b0, "R5 clock cleared by write", 32'(brg_clk[g]), 0);
                    wait_tick(g, 400, n);
                    chk(n == exp_p, p ? "R6 first tick" : (d == 0 ? "R10 first tick" : "R5 first tick"), n, exp_p);
                    chk(brg_clk[g] == 1'b1, "R9 clock high after tick", 32'(brg_clk[g]), 1);
                    wait_tick(g, 400, n);
                    chk(n == exp_p, p ? "R6 period" : (d == 0 ? "R10 period" : "R5 period"), n, exp_p);
                    chk(brg_clk[g] == 1'b0, "R9 clock low after second tick", 32'(brg_clk[g]), 0);
                    wr(g, 0);
                end
            end
        end
        // R7 disabled generators stay quiet, and disabling stops a running one
        wr(2, mk(1'b0, 1'b0, 0));
        wr(6, mk(1'b1, 1'b0, 1));
        wr(6, mk(1'b0, 1'b1, 1));
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            if (brg_tick[2] || brg_clk[2] || brg_tick[6] || brg_clk[6]) n++;
        end
        chk(n == 0, "R7 disabled quiet", n, 0);
        // R8 write to generator 5 mid-period leaves generator 1 phase intact
        wr(1, mk(1'b1, 1'b0, 9));
        wait_tick(1, 100, n);
        k_a = 0; k_b = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            bus_wr = (k == 3); bus_addr = 3'd5; bus_wdata = mk(1'b1, 1'b0, 3);
            @(posedge clk); #1;
            if (brg_tick[5] && k_b == 0) k_b = k;
            if (brg_tick[1] && k_a == 0) k_a = k;
        end
        @(negedge clk); bus_wr = 1'b0;
        chk(k_a == 10, "R8 bystander period", k_a, 10);
        chk(k_b == 7, "R2 R8 written generator first tick", k_b, 7);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #3000000;
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule